// File: doc/BRIEF.md
# Sleep Entry and Wake Sequencer

This block controls how a microcontroller enters and leaves a low-power state. Firmware writes a one to a sleep request bit. The block then waits a fixed number of CPU clock cycles and asserts an output that switches off the analog circuits (references, bias, oscillator, PLL). Firmware is expected to execute its stop instruction inside this window. The block does not check that it does.

A set of asynchronous wake pins feeds the block. Each pin has its own 3-bit source code, which decides whether the pin is a wake source and at which level it wakes. A qualifying wake clears the request bit and the analog shutdown output together. A second, longer fixed delay then lets the oscillator and PLL settle. When that delay ends, the block raises a wake interrupt and holds it until the CPU acknowledges it. A route select bit decides what drives the CPU's interrupt input: the sequencer's wake interrupt or the normal interrupt path.

If a wake arrives while the entry delay is still running, the sleep is abandoned. The analog shutdown output never rises, and the full settle delay still runs before the interrupt.

Top module: `sleep_seq`

## Requirements
- R1: In the idle state, a write with data 1 sets `pdBit` at that clock edge. A write with data 0 leaves it at 0.
- R2: If no wake occurs, `pdAnalog` rises at the 32nd rising edge after the edge that accepted the write. While `pdAnalog` is high, `pdBit` is also high.
- R3: Each wake pin passes through two synchronizing flip-flops. A qualifying wake seen during entry or sleep clears `pdBit` and `pdAnalog` at the third rising edge after the pin changes.
- R4: A pin whose code is 4 qualifies while the pin is high. A pin whose code is 6 qualifies while the pin is low. A pin with any other code never qualifies.
- R5: A wake during the entry delay aborts the sleep: `pdAnalog` never rises, and the wake interrupt still follows after the settle delay.
- R6: The wake interrupt rises at the 512th rising edge after the edge that cleared `pdBit`.
- R7: The wake interrupt stays high until `irqAck` is sampled high. If an acknowledge arrives on the same edge that sets the interrupt, the set wins.
- R8: With `routeWake` at 1, `cpuInt0` shows the wake interrupt. With `routeWake` at 0, `cpuInt0` follows `normIrq`.
- R9: Writes are ignored outside the idle state, and this includes the settle delay.
- R10: While `rstN` is low, all state is idle and `pdBit`, `pdAnalog` and the wake interrupt are 0.
- R11: A qualifying wake during idle or settle has no effect: it neither restarts the settle delay nor raises the interrupt.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | CPU clock |
| rstN | input | 1 | Asynchronous active-low reset |
| ctlWrEn | input | 1 | Write strobe for the sleep request bit |
| ctlWrData | input | 1 | Value written to the sleep request bit |
| wakePins | input | 8 | Asynchronous wake pins |
| pinSrcCode | input | 24 | 3-bit source code per pin; pin i uses bits [3i+2:3i] |
| routeWake | input | 1 | 1: wake interrupt drives cpuInt0; 0: normIrq drives it |
| normIrq | input | 1 | Normal interrupt path |
| irqAck | input | 1 | Clears the wake interrupt |
| pdBit | output | 1 | Sleep request bit |
| pdAnalog | output | 1 | Analog shutdown output |
| cpuInt0 | output | 1 | Interrupt to the CPU |

## Verification
The hardest case to reach is a wake that lands inside the 32-cycle entry window, with the interrupt acknowledge arriving on the exact edge where the interrupt is set. The stimulus drops an active-low pin ten cycles after the request write, so the abort happens mid-window. It then holds the acknowledge high for the whole settle delay, which forces the set and the acknowledge to coincide. A cycle-accurate model in the bench shows whether the interrupt appears for exactly one cycle and whether the shutdown output stays low throughout.

// File: rtl/sleep_seq_pkg.sv
package sleep_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ENTRY  = 2'd1,
    ST_DOWN   = 2'd2,
    ST_SETTLE = 2'd3
  } seqState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic entryClr;
    logic entryEn;
    logic settleClr;
    logic settleEn;
    logic setBit;
    logic clrBit;
    logic setAnalog;
    logic setIrq;
  } seqStrobe_t;

  // status from datapath to control
  typedef struct packed {
    logic entryTc;
    logic settleTc;
    logic wakeQual;
  } seqStatus_t;

endpackage

// File: rtl/sleep_seq_tc_cntr.sv
module sleep_seq_tc_cntr #(
  parameter int LIMIT = 32,
  localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1
) (
  input  logic clk,
  input  logic rstN,
  input  logic ce,
  input  logic clr,
  output logic tc
);
  localparam logic [W-1:0] LAST = W'(LIMIT - 1);

  logic [W-1:0] cnt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)      cnt <= '0;
    else if (clr)   cnt <= '0;
    else if (ce)    cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
  end

  assign tc = ce && (cnt == LAST);

  // after a terminal count the counter restarts from zero
  p_wrap_r2: assert property (@(posedge clk) disable iff (!rstN)
    (tc && !clr) |=> (cnt == '0));

endmodule

// File: rtl/sleep_seq_dp.sv
module sleep_seq_dp
  import sleep_seq_pkg::*;
#(
  parameter int NUM_PINS      = 8,
  parameter int CODE_W        = 3,
  parameter int CODE_ACT_HI   = 4,
  parameter int CODE_ACT_LO   = 6,
  parameter int ENTRY_CYCLES  = 32,
  parameter int SETTLE_CYCLES = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic [NUM_PINS-1:0]        wakePins,
  input  logic [NUM_PINS*CODE_W-1:0] pinSrcCode,
  input  logic                       irqAck,
  input  seqStrobe_t                 strb,
  output seqStatus_t                 status,
  output logic                       pdBit,
  output logic                       pdAnalog,
  output logic                       wakeIrq
);
  localparam logic [CODE_W-1:0] HI_CODE = CODE_W'(CODE_ACT_HI);
  localparam logic [CODE_W-1:0] LO_CODE = CODE_W'(CODE_ACT_LO);

  logic [NUM_PINS-1:0] syncA, syncB, pinHit;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      syncA <= '0;
      syncB <= '0;
    end else begin
      syncA <= wakePins;
      syncB <= syncA;
    end
  end

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
    logic [CODE_W-1:0] code;
    assign code      = pinSrcCode[i*CODE_W +: CODE_W];
    assign pinHit[i] = ((code == HI_CODE) &&  syncB[i]) ||
                       ((code == LO_CODE) && !syncB[i]);
  end

  assign status.wakeQual = |pinHit;

  sleep_seq_tc_cntr #(.LIMIT(ENTRY_CYCLES)) u_entryCnt (
    .clk (clk), .rstN(rstN), .ce(strb.entryEn), .clr(strb.entryClr),
    .tc  (status.entryTc)
  );

  sleep_seq_tc_cntr #(.LIMIT(SETTLE_CYCLES)) u_settleCnt (
    .clk (clk), .rstN(rstN), .ce(strb.settleEn), .clr(strb.settleClr),
    .tc  (status.settleTc)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            pdBit <= 1'b0;
    else if (strb.clrBit) pdBit <= 1'b0;
    else if (strb.setBit) pdBit <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               pdAnalog <= 1'b0;
    else if (strb.clrBit)    pdAnalog <= 1'b0;
    else if (strb.setAnalog) pdAnalog <= 1'b1;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)            wakeIrq <= 1'b0;
    else if (strb.setIrq) wakeIrq <= 1'b1;
    else if (irqAck)      wakeIrq <= 1'b0;
  end

  p_analog_needs_bit_r2: assert property (@(posedge clk) disable iff (!rstN)
    pdAnalog |-> pdBit);

  p_irq_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (wakeIrq && !irqAck) |=> wakeIrq);

  p_irq_set_wins_r7: assert property (@(posedge clk) disable iff (!rstN)
    strb.setIrq |=> wakeIrq);

endmodule

// File: rtl/sleep_seq_ctrl.sv
module sleep_seq_ctrl
  import sleep_seq_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       ctlWrEn,
  input  logic       ctlWrData,
  input  seqStatus_t status,
  output seqStrobe_t strb
);
  seqState_t state, stateNxt;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNxt;
  end

  always_comb begin
    stateNxt = state;
    strb     = '0;
    unique case (state)
      ST_IDLE: begin
        if (ctlWrEn && ctlWrData) begin
          strb.setBit   = 1'b1;
          strb.entryClr = 1'b1;
          stateNxt      = ST_ENTRY;
        end
      end
      ST_ENTRY: begin
        if (status.wakeQual) begin
          // wake wins over a coincident terminal count
          strb.clrBit    = 1'b1;
          strb.settleClr = 1'b1;
          stateNxt       = ST_SETTLE;
        end else begin
          strb.entryEn = 1'b1;
          if (status.entryTc) begin
            strb.setAnalog = 1'b1;
            stateNxt       = ST_DOWN;
          end
        end
      end
      ST_DOWN: begin
        if (status.wakeQual) begin
          strb.clrBit    = 1'b1;
          strb.settleClr = 1'b1;
          stateNxt       = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        strb.settleEn = 1'b1;
        if (status.settleTc) begin
          strb.setIrq = 1'b1;
          stateNxt    = ST_IDLE;
        end
      end
      default: stateNxt = ST_IDLE;
    endcase
  end

  p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.setBit, strb.clrBit, strb.setIrq, strb.setAnalog}));

  p_abort_no_analog_r5: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_ENTRY && status.wakeQual) |=> (state == ST_SETTLE));

endmodule

// File: rtl/sleep_seq.sv
module sleep_seq
  import sleep_seq_pkg::*;
#(
  parameter int NUM_PINS      = 8,
  parameter int CODE_W        = 3,
  parameter int CODE_ACT_HI   = 4,
  parameter int CODE_ACT_LO   = 6,
  parameter int ENTRY_CYCLES  = 32,
  parameter int SETTLE_CYCLES = 512
) (
  input  logic                       clk,
  input  logic                       rstN,
  input  logic                       ctlWrEn,
  input  logic                       ctlWrData,
  input  logic [NUM_PINS-1:0]        wakePins,
  input  logic [NUM_PINS*CODE_W-1:0] pinSrcCode,
  input  logic                       routeWake,
  input  logic                       normIrq,
  input  logic                       irqAck,
  output logic                       pdBit,
  output logic                       pdAnalog,
  output logic                       cpuInt0
);
  seqStrobe_t strb;
  seqStatus_t status;
  logic       wakeIrq;

  sleep_seq_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .status(status), .strb(strb)
  );

  sleep_seq_dp #(
    .NUM_PINS(NUM_PINS), .CODE_W(CODE_W), .CODE_ACT_HI(CODE_ACT_HI),
    .CODE_ACT_LO(CODE_ACT_LO), .ENTRY_CYCLES(ENTRY_CYCLES),
    .SETTLE_CYCLES(SETTLE_CYCLES)
  ) u_dp (
    .clk(clk), .rstN(rstN), .wakePins(wakePins), .pinSrcCode(pinSrcCode),
    .irqAck(irqAck), .strb(strb), .status(status),
    .pdBit(pdBit), .pdAnalog(pdAnalog), .wakeIrq(wakeIrq)
  );

  assign cpuInt0 = routeWake ? wakeIrq : normIrq;

  p_bit_fall_r3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(pdBit) |-> $past(status.wakeQual));

  p_analog_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(pdAnalog) |-> ($past(status.entryTc) && $past(pdBit)));

  p_irq_rise_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(wakeIrq) |-> $past(status.settleTc));

endmodule

// File: tb/sim_sleep_seq.sv
module sim_sleep_seq;
  logic        clk = 1'b0;
  logic        rstN, ctlWrEn, ctlWrData, routeWake, normIrq, irqAck;
  logic [7:0]  wakePins;
  logic [23:0] pinSrcCode;
  logic        pdBit, pdAnalog, cpuInt0;

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  always #10 clk = ~clk;

  sleep_seq u0 (
    .clk(clk), .rstN(rstN), .ctlWrEn(ctlWrEn), .ctlWrData(ctlWrData),
    .wakePins(wakePins), .pinSrcCode(pinSrcCode), .routeWake(routeWake),
    .normIrq(normIrq), .irqAck(irqAck),
    .pdBit(pdBit), .pdAnalog(pdAnalog), .cpuInt0(cpuInt0)
  );

  // behavioural reference: mode 0 idle, 1 entry, 2 down, 3 settle
  int         mMode = 0;
  int         mLeft = 0;
  bit         mBit = 0, mAna = 0, mIrq = 0;
  logic [7:0] mSyncQ[$];

  function automatic bit qualifies(logic [7:0] lvl);
    for (int i = 0; i < 8; i++) begin
      int code = int'(pinSrcCode[i*3 +: 3]);
      if ((code == 4 && lvl[i]) || (code == 6 && !lvl[i])) return 1;
    end
    return 0;
  endfunction

  always @(posedge clk) begin
    if (!rstN) begin
      mMode = 0; mLeft = 0; mBit = 0; mAna = 0; mIrq = 0;
      mSyncQ = '{8'h00, 8'h00};
    end else begin
      bit q;
      q = qualifies(mSyncQ[0]);
      void'(mSyncQ.pop_front());
      mSyncQ.push_back(wakePins);
      if (irqAck) mIrq = 0;
      case (mMode)
        0: if (ctlWrEn && ctlWrData) begin mBit = 1; mMode = 1; mLeft = 32; end
        1: if (q) begin mBit = 0; mMode = 3; mLeft = 512; end
           else begin
             mLeft--;
             if (mLeft == 0) begin mAna = 1; mMode = 2; end
           end
        2: if (q) begin mBit = 0; mAna = 0; mMode = 3; mLeft = 512; end
        default: begin
          mLeft--;
          if (mLeft == 0) begin mIrq = 1; mMode = 0; end
        end
      endcase
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(negedge clk);
    #5;
    if (rstN) begin
      bit eInt;
      eInt = routeWake ? mIrq : normIrq;
      chk(pdBit == mBit,    "R1 model pdBit",    pdBit,    mBit);
      chk(pdAnalog == mAna, "R2 model pdAnalog", pdAnalog, mAna);
      chk(cpuInt0 == eInt,  "R8 model cpuInt0",  cpuInt0,  eInt);
    end
  endtask

  task automatic setCode(input int pin, input int code);
    pinSrcCode[pin*3 +: 3] = 3'(code);
  endtask

  initial begin
    #(20 * 150000);
    errors++;
    checks++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    int  n;
    bit  sawAna;
    rstN = 0; ctlWrEn = 0; ctlWrData = 0; routeWake = 1; normIrq = 0;
    irqAck = 0; wakePins = 8'h00; pinSrcCode = '0;
    repeat (3) tick;
    // R10: reset state
    chk(pdBit == 0 && pdAnalog == 0 && cpuInt0 == 0, "R10 reset outputs",
        {pdBit, pdAnalog, cpuInt0}, 0);
    rstN = 1;
    tick;

    // R1: writing 0 in idle does nothing
    ctlWrEn = 1; ctlWrData = 0; tick; ctlWrEn = 0; tick;
    chk(pdBit == 0, "R1 write0 idle", pdBit, 0);

    // scenario A: normal sleep, active-high wake on pin 2
    setCode(2, 4);
    ctlWrEn = 1; ctlWrData = 1; tick; ctlWrEn = 0;
    chk(pdBit == 1, "R1 write1 sets", pdBit, 1);
    repeat (31) tick;
    chk(pdAnalog == 0, "R2 before 32nd edge", pdAnalog, 0);
    tick;
    chk(pdAnalog == 1, "R2 at 32nd edge", pdAnalog, 1);

    // R4: pin with code 3 is not a wake source
    setCode(0, 3); wakePins[0] = 1;
    repeat (10) tick;
    wakePins[0] = 0;
    chk(pdBit == 1 && pdAnalog == 1, "R4 other code ignored", {pdBit, pdAnalog}, 3);

    // R9: write while asleep ignored
    ctlWrEn = 1; ctlWrData = 0; tick; ctlWrEn = 0; tick;
    chk(pdBit == 1, "R9 write in down ignored", pdBit, 1);

    // R3: wake through two-flop synchronizer
    wakePins[2] = 1;
    tick; tick;
    chk(pdBit == 1, "R3 not before third edge", pdBit, 1);
    tick;
    chk(pdBit == 0 && pdAnalog == 0, "R3 cleared at third edge", {pdBit, pdAnalog}, 0);
    wakePins[2] = 0;

    // R6 / R9 / R11: settle delay, with writes and wakes that must be ignored
    n = 0;
    while (cpuInt0 == 0 && n < 700) begin
      if (n == 5)  begin ctlWrEn = 1; ctlWrData = 1; end
      if (n == 6)  ctlWrEn = 0;
      if (n == 10) wakePins[2] = 1;
      if (n == 15) wakePins[2] = 0;
      tick;
      n++;
      if (n == 20) chk(pdBit == 0, "R9 write in settle ignored", pdBit, 0);
    end
    chk(n == 512, "R6 settle length", n, 512);
    chk(pdBit == 0, "R11 wake in settle ignored", pdBit, 0);

    // R7: irq held until ack
    repeat (5) tick;
    chk(cpuInt0 == 1, "R7 irq held", cpuInt0, 1);
    // R8: route to normal path
    routeWake = 0; normIrq = 0; tick;
    chk(cpuInt0 == 0, "R8 normal path low", cpuInt0, 0);
    normIrq = 1; tick;
    chk(cpuInt0 == 1, "R8 normal path high", cpuInt0, 1);
    routeWake = 1; normIrq = 0;
    irqAck = 1; tick; irqAck = 0;
    chk(cpuInt0 == 0, "R7 ack clears", cpuInt0, 0);

    // R11: wake in idle does nothing
    wakePins[2] = 1; repeat (8) tick; wakePins[2] = 0; repeat (600) tick;
    chk(cpuInt0 == 0 && pdBit == 0, "R11 wake in idle ignored", cpuInt0, 0);

    // scenario B: abort during entry with active-low pin 5, ack held
    setCode(0, 0); setCode(2, 0); setCode(5, 6);
    wakePins[5] = 1; repeat (3) tick;
    ctlWrEn = 1; ctlWrData = 1; tick; ctlWrEn = 0;
    repeat (10) tick;
    wakePins[5] = 0;
    irqAck = 1;
    sawAna = 0; n = 0;
    while (cpuInt0 == 0 && n < 700) begin
      if (n == 3) wakePins[5] = 1;
      tick;
      n++;
      if (pdAnalog) sawAna = 1;
    end
    chk(sawAna == 0, "R5 analog never raised", sawAna, 0);
    chk(cpuInt0 == 1 && n > 512 && n < 520, "R5 irq after abort", n, 515);
    chk(pdBit == 0, "R3 abort cleared bit", pdBit, 0);
    tick;
    chk(cpuInt0 == 0, "R7 set wins then ack clears", cpuInt0, 0);
    irqAck = 0;
    tick;

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule